// File: doc/BRIEF.md
# Scalar Single-to-Double Widening Writeback Unit

This unit takes one IEEE-754 single-precision value and widens it exactly to double precision. It then builds a complete wide vector destination word around that result. The converted value always lands in the low 64-bit lane. How the rest of the word is filled depends on a mode select. In legacy two-operand mode everything above the lane keeps the old destination contents. In the three-operand modes, bits 127:64 come from a first source vector and everything above bit 127 is cleared.

In the masked three-operand mode, a per-element write mask decides whether the low lane is written. When it is not written, the lane either keeps its old value (merging) or is cleared (zeroing). That mode can also suppress all floating-point exception flags. Conversion covers normals, subnormals (normalized exactly, or flushed to a signed zero under a denormals-are-zero control), signed zeros, infinities and NaNs. A signaling NaN is quieted. The whole result passes through a single register stage with a valid-in/valid-out handshake.

Top module: `fpwiden_wb`

## Requirements
- R1: The outputs take one clock. `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, `out_dst` and the flags keep their values. After reset, `out_valid`, `out_dst` and both flags are zero.
- R2: A normal input (exponent field not 0 and not 255) keeps its sign in bit 63. Bits 62:52 hold the exponent field plus 896. Bits 51:29 hold the 23-bit fraction, bits 28:0 are zero, and no flag is raised.
- R3: With `in_daz` low, a subnormal input (exponent 0, fraction nonzero) becomes the exactly equal normal double and raises `out_denormal`.
- R4: With `in_daz` high, a subnormal input becomes a zero of the same sign and raises no flag.
- R5: A zero or an infinity keeps its sign and class, and raises no flag.
- R6: A NaN has exponent 255 and a nonzero fraction. Its output has exponent 2047, bit 51 set, and input fraction bits 21:0 in bits 50:29, with bits 28:0 zero. The input is signaling when fraction bit 22 is 0; then `out_invalid` is raised. A quiet NaN raises no flag.
- R7: `in_mode` 0 is legacy mode, 1 is unmasked three-operand, 2 is masked three-operand, and 3 acts as 1. In legacy mode, `out_dst` bits VEC_W-1:64 equal `in_old_dst` bits VEC_W-1:64.
- R8: In modes 1, 2 and 3, `out_dst` bits 127:64 equal `in_src1_hi`, and bits VEC_W-1:128 are zero.
- R9: In mode 2 the converted value is written to bits 63:0 when `in_mask_en` is 0 or `in_mask0` is 1. In modes 0, 1 and 3 the mask inputs have no effect and the lane is always written.
- R10: In mode 2, when `in_mask_en` is 1 and `in_mask0` is 0, bits 63:0 depend on `in_zeroing`. With `in_zeroing` 0 they equal `in_old_dst` bits 63:0; with `in_zeroing` 1 they are zero. Neither flag is raised in this case.
- R11: In mode 2, `in_sae` high forces both flags to zero. In the other modes `in_sae` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; captures the result |
| in_mode | input | 2 | 0 legacy, 1 three-operand, 2 masked, 3 as 1 |
| in_old_dst | input | VEC_W | Previous destination contents |
| in_src1_hi | input | 64 | Bits 127:64 of the first source vector |
| in_cvt | input | 32 | Single-precision value to widen |
| in_mask0 | input | 1 | Mask bit for element 0 |
| in_mask_en | input | 1 | Masking enabled (mode 2 only) |
| in_zeroing | input | 1 | 1 zeroing, 0 merging for a masked-off lane |
| in_sae | input | 1 | Suppress all exception flags (mode 2 only) |
| in_daz | input | 1 | Flush subnormal inputs to signed zero |
| out_valid | output | 1 | Result valid |
| out_dst | output | VEC_W | New destination word |
| out_invalid | output | 1 | Invalid-operation flag (signaling NaN) |
| out_denormal | output | 1 | Denormal-operand flag |

## Verification
The bench sweeps every combination of mode, mask enable, mask bit, zeroing, suppression and flush control over a fixed set of boundary values, then adds random operands.

Each kind of defect shows up differently:
- A wrong leading-zero count or exponent adjustment gives subnormals that are off by powers of two, most visibly at the smallest and largest subnormal.
- Missing quieting lets a signaling NaN leave with bit 51 clear, or with no invalid flag.
- Swapped merging and zeroing puts stale or cleared data in the masked-off lane.
- An upper-region merge keyed to the wrong mode either leaks old destination bits above bit 127 or loses them in legacy mode.
- Flags that are not gated report exceptions for suppressed or masked-off lanes.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int SP_W     = 32;
  localparam int SP_FRAC  = 23;
  localparam int DP_W     = 64;
  localparam int DP_EXP   = 11;
  localparam int FRAC_SHL = 29;
  localparam logic [DP_EXP-1:0] REBIAS = 11'd896;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_VEC3   = 2'd1,
    MODE_MASKED = 2'd2,
    MODE_VEC3B  = 2'd3
  } fpw_mode_e;

  typedef struct packed {
    logic invalid;
    logic denormal;
  } fpw_flags_t;
endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
  parameter int W  = 23,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpw_widen.sv
module fpw_widen
  import fpw_pkg::*;
(
  input  logic [SP_W-1:0] sp,
  input  logic            daz,
  output logic [DP_W-1:0] dp,
  output fpw_flags_t      flags
);
  localparam int LZ_W = $clog2(SP_FRAC + 1);

  logic              sgn;
  logic [7:0]        exp_f;
  logic [SP_FRAC-1:0] frac;
  logic [LZ_W-1:0]   lz;
  logic [SP_FRAC:0]  norm;

  assign sgn   = sp[31];
  assign exp_f = sp[30:23];
  assign frac  = sp[22:0];

  fpw_lzc #(.W(SP_FRAC), .CW(LZ_W)) u_lzc (.vec(frac), .cnt(lz));

  always_comb begin
    norm  = {1'b0, frac} << ({1'b0, lz} + 6'd1);
    dp    = '0;
    flags = '0;
    if (exp_f == 8'd0) begin
      if (frac == '0 || daz) begin
        dp = {sgn, 63'd0};
      end else begin
        dp = {sgn, REBIAS - DP_EXP'(lz), norm[SP_FRAC-1:0], {FRAC_SHL{1'b0}}};
        flags.denormal = 1'b1;
      end
    end else if (exp_f == 8'hFF) begin
      if (frac == '0) begin
        dp = {sgn, {DP_EXP{1'b1}}, 52'd0};
      end else begin
        dp = {sgn, {DP_EXP{1'b1}}, 1'b1, frac[21:0], {FRAC_SHL{1'b0}}};
        flags.invalid = ~frac[22];
      end
    end else begin
      dp = {sgn, {3'b000, exp_f} + REBIAS, frac, {FRAC_SHL{1'b0}}};
    end
  end
endmodule

// File: rtl/fpw_assemble.sv
module fpw_assemble
  import fpw_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic [1:0]       mode,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [63:0]      src1_hi,
  input  logic [DP_W-1:0]  conv,
  input  fpw_flags_t       conv_flags,
  input  logic             mask0,
  input  logic             mask_en,
  input  logic             zeroing,
  input  logic             sae,
  output logic [VEC_W-1:0] dst,
  output fpw_flags_t       flags
);
  localparam int HI_W = VEC_W - DP_W;

  logic             masked_mode;
  logic             lane_we;
  logic [HI_W-1:0]  hi_three;
  logic [DP_W-1:0]  lane;

  generate
    if (VEC_W > 128) begin : g_wide
      assign hi_three = {{(VEC_W - 128){1'b0}}, src1_hi};
    end else begin : g_narrow
      assign hi_three = src1_hi;
    end
  endgenerate

  always_comb begin
    masked_mode = (fpw_mode_e'(mode) == MODE_MASKED);
    lane_we     = !masked_mode || !mask_en || mask0;
    if (lane_we)      lane = conv;
    else if (zeroing) lane = '0;
    else              lane = old_dst[DP_W-1:0];
    if (fpw_mode_e'(mode) == MODE_LEGACY) dst = {old_dst[VEC_W-1:DP_W], lane};
    else                                  dst = {hi_three, lane};
    if (lane_we && !(masked_mode && sae)) flags = conv_flags;
    else                                  flags = '0;
  end
endmodule

// File: rtl/fpwiden_wb.sv
module fpwiden_wb
  import fpw_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic [VEC_W-1:0] in_old_dst,
  input  logic [63:0]      in_src1_hi,
  input  logic [31:0]      in_cvt,
  input  logic             in_mask0,
  input  logic             in_mask_en,
  input  logic             in_zeroing,
  input  logic             in_sae,
  input  logic             in_daz,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_dst,
  output logic             out_invalid,
  output logic             out_denormal
);
  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  logic [DP_W-1:0]  conv;
  fpw_flags_t       conv_flags;
  logic [VEC_W-1:0] dst_d;
  fpw_flags_t       flags_d;
  logic [VEC_W-1:0] dst_q;
  fpw_flags_t       flags_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  fpw_widen u_widen (
    .sp    (in_cvt),
    .daz   (in_daz),
    .dp    (conv),
    .flags (conv_flags)
  );

  fpw_assemble #(.VEC_W(VEC_W)) u_asm (
    .mode       (in_mode),
    .old_dst    (in_old_dst),
    .src1_hi    (in_src1_hi),
    .conv       (conv),
    .conv_flags (conv_flags),
    .mask0      (in_mask0),
    .mask_en    (in_mask_en),
    .zeroing    (in_zeroing),
    .sae        (in_sae),
    .dst        (dst_d),
    .flags      (flags_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      dst_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        dst_q   <= dst_d;
        flags_q <= flags_d;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_dst      = dst_q;
  assign out_invalid  = flags_q.invalid;
  assign out_denormal = flags_q.denormal;
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker #(
  parameter int VEC_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_mode,
  input logic [VEC_W-1:0] in_old_dst,
  input logic [63:0]      in_src1_hi,
  input logic [31:0]      in_cvt,
  input logic             in_mask0,
  input logic             in_mask_en,
  input logic             in_zeroing,
  input logic             in_sae,
  input logic             in_daz,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_dst,
  input logic             out_invalid,
  input logic             out_denormal
);
  logic lane_off;
  logic is_normal;
  assign lane_off  = in_mode == 2'd2 && in_mask_en && !in_mask0;
  assign is_normal = in_cvt[30:23] != 8'd0 && in_cvt[30:23] != 8'hFF;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_dst) && $stable(out_invalid));
  a_r2_normal_fields: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode != 2'd2 && is_normal |=>
      out_dst[63] == $past(in_cvt[31]) && out_dst[51:29] == $past(in_cvt[22:0])
      && out_dst[28:0] == 29'd0 && !out_invalid && !out_denormal);
  a_r4_daz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_daz && in_cvt[30:23] == 8'd0 |=> !out_denormal);
  a_r7_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'd0 |=> out_dst[VEC_W-1:64] == $past(in_old_dst[VEC_W-1:64]));
  a_r8_src1_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode != 2'd0 |=> out_dst[127:64] == $past(in_src1_hi));
  generate
    if (VEC_W > 128) begin : g_top
      a_r8_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_mode != 2'd0 |=> out_dst[VEC_W-1:128] == '0);
    end
  endgenerate
  a_r10_zeroing: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_off && in_zeroing |=>
      out_dst[63:0] == 64'd0 && !out_invalid && !out_denormal);
  a_r10_merging: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_off && !in_zeroing |=> out_dst[63:0] == $past(in_old_dst[63:0]));
  a_r11_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'd2 && in_sae |=> !out_invalid && !out_denormal);
endmodule

bind fpwiden_wb fpw_checker #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .in_valid     (in_valid),
  .in_mode      (in_mode),
  .in_old_dst   (in_old_dst),
  .in_src1_hi   (in_src1_hi),
  .in_cvt       (in_cvt),
  .in_mask0     (in_mask0),
  .in_mask_en   (in_mask_en),
  .in_zeroing   (in_zeroing),
  .in_sae       (in_sae),
  .in_daz       (in_daz),
  .out_valid    (out_valid),
  .out_dst      (out_dst),
  .out_invalid  (out_invalid),
  .out_denormal (out_denormal)
);

// File: tb/fpwiden_wb_tb.sv
module fpwiden_wb_tb;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_mode = '0;
  logic [VW-1:0] in_old_dst = '0;
  logic [63:0]   in_src1_hi = '0;
  logic [31:0]   in_cvt = '0;
  logic          in_mask0 = 1'b0, in_mask_en = 1'b0, in_zeroing = 1'b0;
  logic          in_sae = 1'b0, in_daz = 1'b0;
  logic          out_valid;
  logic [VW-1:0] out_dst;
  logic          out_invalid, out_denormal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  fpwiden_wb #(.VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_old_dst(in_old_dst), .in_src1_hi(in_src1_hi), .in_cvt(in_cvt),
    .in_mask0(in_mask0), .in_mask_en(in_mask_en), .in_zeroing(in_zeroing),
    .in_sae(in_sae), .in_daz(in_daz), .out_valid(out_valid), .out_dst(out_dst),
    .out_invalid(out_invalid), .out_denormal(out_denormal)
  );

  // Returns {invalid, denormal, double}
  function automatic logic [65:0] ref_conv(input logic [31:0] a, input logic daz);
    logic [23:0] m;
    int          e;
    int          k;
    if (a[30:23] == 8'd0) begin
      if (a[22:0] == 23'd0 || daz) return {2'b00, a[31], 63'd0};
      m = {1'b0, a[22:0]};
      k = 0;
      while (m[23] == 1'b0) begin
        m = m << 1;
        k = k + 1;
      end
      e = 897 - k;
      return {2'b01, a[31], 11'(e), m[22:0], 29'd0};
    end else if (a[30:23] == 8'hFF) begin
      if (a[22:0] == 23'd0) return {2'b00, a[31], 11'h7FF, 52'd0};
      return {~a[22], 1'b0, a[31], 11'h7FF, 1'b1, a[21:0], 29'd0};
    end
    e = int'(a[30:23]) - 127 + 1023;
    return {2'b00, a[31], 11'(e), a[22:0], 29'd0};
  endfunction

  function automatic string class_tag(input logic [31:0] a, input logic daz);
    if (a[30:23] == 8'hFF) return (a[22:0] == 0) ? "R5" : "R6";
    if (a[30:23] == 8'd0) begin
      if (a[22:0] == 0) return "R5";
      return daz ? "R4" : "R3";
    end
    return "R2";
  endfunction

  function automatic logic [31:0] special(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h7F80_0000;  3: return 32'hFF80_0000;
      4: return 32'h7FC0_0001;  5: return 32'hFFA0_0005;
      6: return 32'h7F80_0001;  7: return 32'h0000_0001;
      8: return 32'h807F_FFFF;  9: return 32'h0040_0000;
      10: return 32'h3F80_0000; 11: return 32'h0080_0000;
      12: return 32'h7F7F_FFFF; default: return 32'hC049_0FDB;
    endcase
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] md, input logic [31:0] a, input logic m0,
                         input logic me, input logic z, input logic s, input logic dz);
    logic [VW-1:0] old_v;
    logic [63:0]   s1;
    logic [65:0]   r;
    logic          we, off;
    logic [63:0]   lane;
    logic [1:0]    fl;
    logic [VW-1:0] exp_v;
    string         ltag, ftag;
    old_v = rand_vec();
    s1    = {$urandom, $urandom};
    @(negedge clk);
    in_valid = 1'b1; in_mode = md; in_old_dst = old_v; in_src1_hi = s1; in_cvt = a;
    in_mask0 = m0; in_mask_en = me; in_zeroing = z; in_sae = s; in_daz = dz;
    r    = ref_conv(a, dz);
    off  = (md == 2'd2) && me && !m0;
    we   = !off;
    lane = we ? r[63:0] : (z ? 64'd0 : old_v[63:0]);
    fl   = (we && !(md == 2'd2 && s)) ? r[65:64] : 2'b00;
    if (md == 2'd0) exp_v = {old_v[VW-1:64], lane};
    else            exp_v = {{(VW-128){1'b0}}, s1, lane};
    ltag = off ? "R10" : ((md == 2'd2) ? "R9" : class_tag(a, dz));
    ftag = off ? "R10" : ((md == 2'd2 && s) ? "R11" : class_tag(a, dz));
    @(negedge clk);
    check(ltag, {{(VW-64){1'b0}}, out_dst[63:0]}, {{(VW-64){1'b0}}, exp_v[63:0]});
    check((md == 2'd0) ? "R7" : "R8", {out_dst[VW-1:64], 64'd0}, {exp_v[VW-1:64], 64'd0});
    check(ftag, VW'({out_invalid, out_denormal}), VW'(fl));
    check("R1", VW'(out_valid), VW'(1'b1));
    // idle cycle with changed inputs: outputs must hold
    in_valid = 1'b0; in_old_dst = rand_vec(); in_cvt = $urandom; in_mode = 2'($urandom);
    @(negedge clk);
    check("R1", out_dst, exp_v);
    check("R1", VW'({out_valid, out_invalid, out_denormal}), VW'({1'b0, fl}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1", {out_dst[VW-1:3], out_valid, out_invalid, out_denormal}, '0);
    check("R1", out_dst, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 128; c++) begin
      for (int v = 0; v < 14; v++) begin
        run_vec(2'(c[1:0]), special(v), c[2], c[3], c[4], c[5], c[6]);
      end
    end
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a;
      a = $urandom;
      if (n % 4 == 1) a[30:23] = 8'd0;
      if (n % 4 == 2) a[30:23] = 8'hFF;
      run_vec(2'($urandom), a, 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule